// File: doc/BRIEF.md
# Packed SIMD Integer Lane Unit

The unit takes two 128-bit operands, a destination vector and a source vector, and applies one packed integer operation chosen by a 4-bit operation code. The available operations are:

- a rounded, scaled high multiply on signed 16-bit lanes;
- a three-way conditional sign on 8-, 16- or 32-bit lanes;
- an absolute value on 8-, 16- or 32-bit lanes;
- a pairwise multiply-add of signed 16-bit lanes into 32-bit sums;
- a pairwise multiply-add of unsigned destination bytes by signed source bytes into saturated 16-bit words.

Requests arrive through a valid/ready handshake, and the unit registers the result. In every operation, lane i occupies bits [i*EW +: EW] of a vector, so lane 0 is the least significant.

A request is accepted on a rising clock edge where `in_valid_i` and `in_ready_o` are both high. The result register and `out_valid_o` update on that same edge, so the result is visible in the cycle after acceptance. The result then stays on `result_o` until a cycle in which `out_ready_i` is high. A new request can be accepted in the same cycle that the previous result is consumed, which allows one operation per cycle.

Top module: `simd_lane_unit`

## Requirements
- R1: Op code 0 (rounded high multiply): each 16-bit result lane equals bits [30:15] of (dest_lane * src_lane + 0x4000), with both lanes signed. For example, 0x8000 times 0x8000 gives 0x8000.
- R2: Op codes 1, 2 and 3 (conditional sign on 8-, 16- and 32-bit lanes): each result lane is the two's-complement negation of the dest lane when the src lane is negative, zero when the src lane is zero, and the dest lane unchanged when the src lane is positive.
- R3: Op codes 4, 5 and 6 (absolute value on 8-, 16- and 32-bit lanes): each result lane is the magnitude of the src lane, read as unsigned. The most negative value maps to itself, for example 0x80 to 0x80. The dest operand has no effect on the result.
- R4: Op code 7 (word multiply-add): each 32-bit result lane j equals d[2j]*s[2j] + d[2j+1]*s[2j+1], where d and s are the signed 16-bit lanes. The sum is taken modulo 2^32 with no saturation, so four 0x8000 inputs give 0x80000000.
- R5: Op code 8 (byte multiply-add): each 16-bit result lane k equals the unsigned dest byte 2k times the signed src byte 2k, plus the same product for bytes 2k+1. The sum is saturated to the signed 16-bit range [0x8000, 0x7FFF].
- R6: Op codes 9 to 15 produce an all-zero result.
- R7: After an accepted request, `out_valid_o` is high and `result_o` holds that request's result in the next cycle.
- R8: While `out_valid_o` is high and `out_ready_i` is low, `in_ready_o` is low and both `out_valid_o` and `result_o` hold their values. When the result is consumed with no new request, `out_valid_o` falls.
- R9: During reset, `out_valid_o` is low, `result_o` is zero and `in_ready_o` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Request valid |
| in_ready_o | output | 1 | Unit can accept a request |
| op_i | input | 4 | Operation code |
| dest_i | input | 128 | Destination operand |
| src_i | input | 128 | Source operand |
| out_valid_o | output | 1 | Result valid |
| out_ready_i | input | 1 | Consumer takes the result |
| result_o | output | 128 | Registered result |

## Verification
The assertions check the handshake on every cycle:
- an accepted request raises `out_valid_o`;
- a stalled result holds both `out_valid_o` and `result_o`, and `in_ready_o` stays low during the stall;
- an accepted unused op code yields zero.

They also check, on every cycle, that an absolute-value byte lane can have its top bit set only for the input 0x80. The lane arithmetic itself can only be shown by the bench's scenarios, which compare full vectors against an independent model. These scenarios cover the multiply rounding edge at 0x8000, the three sign cases at each element size, the wrap of the word multiply-add, and both saturation limits of the byte multiply-add.

// File: rtl/simd_lane_pkg.sv
`timescale 1ns/1ps
package simd_lane_pkg;
  localparam int unsigned VEC_W  = 128;
  localparam int unsigned OP_W   = 4;

  typedef enum logic [OP_W-1:0] {
    OP_MULHRS  = 4'd0,
    OP_SGN_B   = 4'd1,
    OP_SGN_W   = 4'd2,
    OP_SGN_D   = 4'd3,
    OP_ABS_B   = 4'd4,
    OP_ABS_W   = 4'd5,
    OP_ABS_D   = 4'd6,
    OP_MADD_WD = 4'd7,
    OP_MADD_UB = 4'd8
  } lane_op_e;
endpackage

// File: rtl/simd_sign_abs.sv
`timescale 1ns/1ps
// Conditional sign and absolute value for one element width
module simd_sign_abs #(
  parameter int unsigned VEC_W = 128,
  parameter int unsigned EW    = 8
) (
  input  logic [VEC_W-1:0] dest_i,
  input  logic [VEC_W-1:0] src_i,
  output logic [VEC_W-1:0] sign_o,
  output logic [VEC_W-1:0] abs_o
);
  localparam int unsigned NLANE = VEC_W / EW;

  for (genvar i = 0; i < NLANE; i++) begin : g_lane
    logic [EW-1:0] d, s;
    logic          s_neg, s_zero;
    assign d      = dest_i[i*EW +: EW];
    assign s      = src_i[i*EW +: EW];
    assign s_neg  = s[EW-1];
    assign s_zero = (s == '0);
    assign sign_o[i*EW +: EW] = s_neg ? (~d + 1'b1) : (s_zero ? '0 : d);
    assign abs_o[i*EW +: EW]  = s_neg ? (~s + 1'b1) : s;
  end
endmodule

// File: rtl/simd_word_mul.sv
`timescale 1ns/1ps
// Signed 16x16 products shared by rounded high multiply and word multiply-add
module simd_word_mul #(
  parameter int unsigned VEC_W = 128
) (
  input  logic [VEC_W-1:0] dest_i,
  input  logic [VEC_W-1:0] src_i,
  output logic [VEC_W-1:0] mulhrs_o,
  output logic [VEC_W-1:0] madd_o
);
  localparam int unsigned NW = VEC_W / 16;
  localparam int unsigned ND = VEC_W / 32;

  logic signed [31:0] prod [NW];

  for (genvar i = 0; i < NW; i++) begin : g_prod
    logic signed [31:0] rnd;
    logic               unused_rnd;
    assign prod[i] = $signed(dest_i[i*16 +: 16]) * $signed(src_i[i*16 +: 16]);
    assign rnd     = prod[i] + 32'sh0000_4000;
    assign mulhrs_o[i*16 +: 16] = rnd[30:15];
    assign unused_rnd = ^{rnd[31], rnd[14:0]};
  end

  for (genvar j = 0; j < ND; j++) begin : g_madd
    // wraps modulo 2^32 by design
    assign madd_o[j*32 +: 32] = prod[2*j] + prod[2*j+1];
  end
endmodule

// File: rtl/simd_byte_madd.sv
`timescale 1ns/1ps
// Unsigned-by-signed byte multiply-add with signed word saturation
module simd_byte_madd #(
  parameter int unsigned VEC_W = 128
) (
  input  logic [VEC_W-1:0] dest_i,
  input  logic [VEC_W-1:0] src_i,
  output logic [VEC_W-1:0] madd_o
);
  localparam int unsigned NW = VEC_W / 16;
  localparam logic signed [17:0] SAT_HI = 18'sd32767;
  localparam logic signed [17:0] SAT_LO = -18'sd32768;

  for (genvar k = 0; k < NW; k++) begin : g_word
    logic signed [16:0] p_lo, p_hi;
    logic signed [17:0] sum;
    logic               unused_sum;
    assign p_lo = $signed({1'b0, dest_i[k*16 +: 8]})     * $signed(src_i[k*16 +: 8]);
    assign p_hi = $signed({1'b0, dest_i[k*16+8 +: 8]})   * $signed(src_i[k*16+8 +: 8]);
    assign sum  = 18'(p_lo) + 18'(p_hi);
    assign unused_sum = ^sum[17:16];
    always_comb begin
      if (sum > SAT_HI)      madd_o[k*16 +: 16] = 16'h7fff;
      else if (sum < SAT_LO) madd_o[k*16 +: 16] = 16'h8000;
      else                   madd_o[k*16 +: 16] = sum[15:0];
    end
  end
endmodule

// File: rtl/simd_lane_unit.sv
`timescale 1ns/1ps
module simd_lane_unit
  import simd_lane_pkg::*;
#(
  parameter int unsigned VW = VEC_W
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            in_valid_i,
  output logic            in_ready_o,
  input  logic [OP_W-1:0] op_i,
  input  logic [VW-1:0]   dest_i,
  input  logic [VW-1:0]   src_i,
  output logic            out_valid_o,
  input  logic            out_ready_i,
  output logic [VW-1:0]   result_o
);
  localparam int unsigned NSZ = 3;  // byte, word, dword

  logic [VW-1:0] sign_v [NSZ];
  logic [VW-1:0] abs_v  [NSZ];
  logic [VW-1:0] mulhrs_v, madd_wd_v, madd_ub_v, next_res;
  logic [VW-1:0] res_q;
  logic          valid_q, acc;

  for (genvar z = 0; z < NSZ; z++) begin : g_size
    simd_sign_abs #(.VEC_W(VW), .EW(8 << z)) u_sign_abs (
      .dest_i (dest_i),
      .src_i  (src_i),
      .sign_o (sign_v[z]),
      .abs_o  (abs_v[z])
    );
  end

  simd_word_mul #(.VEC_W(VW)) u_word_mul (
    .dest_i   (dest_i),
    .src_i    (src_i),
    .mulhrs_o (mulhrs_v),
    .madd_o   (madd_wd_v)
  );

  simd_byte_madd #(.VEC_W(VW)) u_byte_madd (
    .dest_i (dest_i),
    .src_i  (src_i),
    .madd_o (madd_ub_v)
  );

  always_comb begin
    unique case (op_i)
      OP_MULHRS:  next_res = mulhrs_v;
      OP_SGN_B:   next_res = sign_v[0];
      OP_SGN_W:   next_res = sign_v[1];
      OP_SGN_D:   next_res = sign_v[2];
      OP_ABS_B:   next_res = abs_v[0];
      OP_ABS_W:   next_res = abs_v[1];
      OP_ABS_D:   next_res = abs_v[2];
      OP_MADD_WD: next_res = madd_wd_v;
      OP_MADD_UB: next_res = madd_ub_v;
      default:    next_res = '0;
    endcase
  end

  assign in_ready_o = !valid_q || out_ready_i;
  assign acc        = in_valid_i && in_ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      res_q   <= '0;
    end else if (acc) begin
      valid_q <= 1'b1;
      res_q   <= next_res;
    end else if (out_ready_i) begin
      valid_q <= 1'b0;
    end
  end

  assign out_valid_o = valid_q;
  assign result_o    = res_q;

  // R7
  accept_raises_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc |=> out_valid_o);

  // R8
  stall_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(result_o)));

  // R8
  stall_not_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i) |-> !in_ready_o);

  // R6
  unused_op_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && op_i > OP_MADD_UB) |=> (result_o == '0));

  // R3
  abs_top_bit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abs_v[0][7] |-> (src_i[7:0] == 8'h80));
endmodule

// File: tb/simd_lane_unit_bench.sv
`timescale 1ns/1ps
module simd_lane_unit_bench;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0, out_ready = 1'b1;
  logic [3:0]   op = '0;
  logic [127:0] dest = '0, src = '0;
  logic         in_ready, out_valid;
  logic [127:0] result;
  int           n_chk = 0, n_fail = 0;

  always #4 clk = ~clk;

  simd_lane_unit u_simd_lane_unit (
    .clk_i(clk), .rst_ni(rst_n), .in_valid_i(in_valid), .in_ready_o(in_ready),
    .op_i(op), .dest_i(dest), .src_i(src), .out_valid_o(out_valid),
    .out_ready_i(out_ready), .result_o(result)
  );

  function automatic longint sx(input logic [127:0] v, input int pos, input int ew);
    longint x = longint'((v >> (pos * ew)) & ((128'd1 << ew) - 1));
    if (x >= (longint'(1) << (ew - 1))) x -= (longint'(1) << ew);
    return x;
  endfunction

  function automatic logic [127:0] put(input logic [127:0] r, input longint x,
                                       input int pos, input int ew);
    logic [127:0] m = (128'd1 << ew) - 1;
    logic [127:0] v = 128'(x) & m;
    return (r & ~(m << (pos * ew))) | (v << (pos * ew));
  endfunction

  function automatic logic [127:0] model(input logic [3:0] o, input logic [127:0] d, s);
    logic [127:0] r = '0;
    int ew;
    case (o)
      4'd0: for (int i = 0; i < 8; i++) r = put(r, (sx(d,i,16) * sx(s,i,16) + 16384) >>> 15, i, 16);
      4'd1, 4'd2, 4'd3: begin
        ew = 8 << (o - 1);
        for (int i = 0; i < 128 / ew; i++) begin
          longint sv = sx(s, i, ew), dv = sx(d, i, ew);
          r = put(r, (sv < 0) ? -dv : ((sv == 0) ? 0 : dv), i, ew);
        end
      end
      4'd4, 4'd5, 4'd6: begin
        ew = 8 << (o - 4);
        for (int i = 0; i < 128 / ew; i++) begin
          longint sv = sx(s, i, ew);
          r = put(r, (sv < 0) ? -sv : sv, i, ew);
        end
      end
      4'd7: for (int j = 0; j < 4; j++)
              r = put(r, sx(d,2*j,16)*sx(s,2*j,16) + sx(d,2*j+1,16)*sx(s,2*j+1,16), j, 32);
      4'd8: for (int k = 0; k < 8; k++) begin
              longint sm = longint'(d[k*16 +: 8]) * sx(s, 2*k, 8)
                         + longint'(d[k*16+8 +: 8]) * sx(s, 2*k+1, 8);
              if (sm > 32767) sm = 32767;
              if (sm < -32768) sm = -32768;
              r = put(r, sm, k, 16);
            end
      default: r = '0;
    endcase
    return r;
  endfunction

  task automatic chk(input string req, input logic [127:0] act, exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_op(input string req, input logic [3:0] o, input logic [127:0] d, s);
    @(negedge clk);
    in_valid = 1'b1; op = o; dest = d; src = s;
    @(negedge clk);
    in_valid = 1'b0;
    chk({req, " valid"}, 128'(out_valid), 128'd1);
    chk(req, result, model(o, d, s));
  endtask

  task automatic t_reset;
    // R9
    chk("R9 out_valid", 128'(out_valid), 128'd0);
    chk("R9 result", result, '0);
    chk("R9 in_ready", 128'(in_ready), 128'd1);
  endtask

  task automatic t_mulhrs;
    do_op("R1", 4'd0, 128'h8000_7fff_0001_4000_c000_ffff_1234_8000,
                      128'h8000_7fff_ffff_4000_4000_0001_5678_7fff);
    // R1 edge: 0x8000*0x8000 -> 0x8000 in every lane
    do_op("R1 edge", 4'd0, {8{16'h8000}}, {8{16'h8000}});
    chk("R1 edge const", result, {8{16'h8000}});
  endtask

  task automatic t_sign;
    for (int o = 1; o <= 3; o++)
      do_op("R2", 4'(o), 128'h7f80_0102_8000_ffff_1234_5678_9abc_def0,
                         128'h8000_0000_7fff_0001_ff00_00ff_8000_0001);
  endtask

  task automatic t_abs;
    for (int o = 4; o <= 6; o++)
      do_op("R3", 4'(o), 128'h1111_2222_3333_4444_5555_6666_7777_8888,
                         128'h8000_0000_8000_0000_80ff_7f01_ffff_8001);
    do_op("R3 most-neg", 4'd4, '1, {16{8'h80}});
    chk("R3 most-neg const", result, {16{8'h80}});
    // R3 dest has no effect
    do_op("R3 dest ignored", 4'd5, '0, 128'h8000_0000_8000_0000_80ff_7f01_ffff_8001);
  endtask

  task automatic t_madd_wd;
    do_op("R4 wrap", 4'd7, {8{16'h8000}}, {8{16'h8000}});
    chk("R4 wrap const", result, {4{32'h8000_0000}});
    do_op("R4", 4'd7, 128'h0003_fffe_7fff_8000_1234_0001_ffff_ffff,
                      128'h0005_0007_7fff_7fff_0002_8000_0001_ffff);
  endtask

  task automatic t_madd_ub;
    do_op("R5 sat hi", 4'd8, '1, {16{8'h7f}});
    chk("R5 sat hi const", result, {8{16'h7fff}});
    do_op("R5 sat lo", 4'd8, '1, {16{8'h80}});
    chk("R5 sat lo const", result, {8{16'h8000}});
    do_op("R5", 4'd8, 128'h0102_ff80_7f01_0010_8080_00ff_3456_ffff,
                      128'hff02_0180_7f7f_f010_8080_7f01_c340_0101);
  endtask

  task automatic t_unused;
    for (int o = 9; o <= 15; o++) begin
      do_op("R6", 4'(o), '1, 128'h8000_0000_8000_0000_80ff_7f01_ffff_8001);
      chk("R6 zero", result, '0);
    end
  endtask

  task automatic t_hold;
    logic [127:0] first;
    @(negedge clk);
    out_ready = 1'b0;
    do_op("R7", 4'd2, 128'h0001_0002_0003_0004_0005_0006_0007_0008,
                      128'hffff_0000_0001_ffff_0000_0001_ffff_0001);
    first = result;
    in_valid = 1'b1; op = 4'd4; dest = '0; src = {16{8'hff}};
    repeat (2) begin
      @(negedge clk);
      // R8
      chk("R8 in_ready low", 128'(in_ready), 128'd0);
      chk("R8 valid held", 128'(out_valid), 128'd1);
      chk("R8 result held", result, first);
    end
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R7 next accept", result, {16{8'h01}});
    @(negedge clk);
    chk("R8 valid falls", 128'(out_valid), 128'd0);
  endtask

  task automatic t_random;
    for (int n = 0; n < 60; n++) begin
      logic [127:0] d = {$urandom, $urandom, $urandom, $urandom};
      logic [127:0] s = {$urandom, $urandom, $urandom, $urandom};
      do_op("R1-R5 mix", 4'($urandom % 9), d, s);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_mulhrs();
    t_sign();
    t_abs();
    t_madd_wd();
    t_madd_ub();
    t_unused();
    t_hold();
    t_random();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule